// File: doc/BRIEF.md
# Programmable one-dimensional cellular automaton

This block is a ring of single-bit cells. Each cell keeps its state in one flip-flop. On every step it computes its next state from its left neighbour, itself and its right neighbour. It does so through its own eight-entry rule table, so the array can run a different local rule in every position. Rules are loaded one cell at a time through a configuration port, and only while the array is halted.

A starting pattern comes either from a user-supplied vector or from an internal 16-bit LFSR. The LFSR is expanded across the whole ring. The array then either free-runs, one step per clock, or advances one step per pulse. The full cell vector is always visible at the output. A detector raises a flag once the whole ring has settled into global synchronization: every cell equal, and all of them toggling together, for four steps in a row.

Top module: `ca_ring`

## Requirements
- R1: After reset every cell reads 0, every rule table holds 0x00, the sync flag is low and the LFSR holds 0xACE1.
- R2: On a step, cell i takes bit {left, self, right} of its own rule. The left neighbour is the MSB of that 3-bit index, and the left neighbour of cell i is cell i-1.
- R3: The ring is cyclic. The left neighbour of cell 0 is cell N-1, and the right neighbour of cell N-1 is cell 0.
- R4: Each cell uses only its own rule byte, so different cells can follow different rules in the same step.
- R5: A rule write (address = cell index, 8-bit data) takes effect only while run is low. Writes made while run is high, and writes to addresses of N or above, change nothing.
- R6: While run is high the array advances one step per clock. While run is low it advances exactly once for each cycle that step is high. Otherwise it holds.
- R7: A seed load with the source select high copies the user pattern into the cells. A seed load takes priority over any step in the same cycle.
- R8: A seed load with the source select low fills cells 16k+b with bit b of the k-th successive LFSR state, starting from the current one (k = 0..3). The LFSR steps by a right shift, XORing in 0xB400 when the bit shifted out is 1. After the load the LFSR holds the fourth successor.
- R9: The sync flag goes high at the step that completes 4 consecutive steps in which the ring goes from uniform to the opposite uniform value. It stays high while further steps alternate. It drops at a non-alternating step or at a seed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Free-run enable; also locks the rule tables |
| step_req | input | 1 | Single-step request while halted |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | 6 | Cell index for the rule write |
| cfg_rule | input | 8 | Rule byte to write |
| seed_load | input | 1 | Load a starting pattern |
| seed_src | input | 1 | 1 = user pattern, 0 = LFSR expansion |
| seed_user | input | 56 | User starting pattern |
| cells_q | output | 56 | Current state of all cells |
| sync_flag | output | 1 | Global synchronization detected |

## Verification
The assertions check four things on every cycle. The cells hold when nothing advances or loads. The rule tables never change while run is high. The sync flag only sits on a uniform ring and only rises on a step that changed it. The LFSR never reaches zero. The exact next-state mapping, the per-cell rules, the wrap-around at both ends, the LFSR expansion order and the four-step threshold of the detector depend on chosen data. Only the bench scenarios can show these, by comparing against an independent step model.

// File: rtl/ca_ring.sv
module ca_ring #(
  parameter int N_CELLS = 56,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1,
  parameter int SYNC_STEPS = 4,
  localparam int ADDR_W = $clog2(N_CELLS),
  localparam int SEED_WORDS = (N_CELLS + LFSR_W - 1) / LFSR_W,
  localparam int CNT_W = $clog2(SYNC_STEPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               step_req,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_rule,
  input  logic               seed_load,
  input  logic               seed_src,
  input  logic [N_CELLS-1:0] seed_user,
  output logic [N_CELLS-1:0] cells_q,
  output logic               sync_flag
);

  logic [N_CELLS-1:0][7:0]          rule_q;
  logic [LFSR_W-1:0]                lfsr_q, lfsr_end;
  logic [SEED_WORDS*LFSR_W-1:0]     seed_wide;
  logic [N_CELLS-1:0]               nxt;
  logic [CNT_W-1:0]                 alt_cnt;
  logic                             advance, cur_uni, nxt_uni, alt_step, rule_ok;

  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction

  always_comb begin
    logic [LFSR_W-1:0] walk;
    walk = lfsr_q;
    seed_wide = '0;
    for (int w = 0; w < SEED_WORDS; w++) begin
      seed_wide[w*LFSR_W +: LFSR_W] = walk;
      walk = lfsr_adv(walk);
    end
    lfsr_end = walk;
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam int LI = (i + N_CELLS - 1) % N_CELLS;
    localparam int RI = (i + 1) % N_CELLS;
    assign nxt[i] = rule_q[i][{cells_q[LI], cells_q[i], cells_q[RI]}];
  end

  assign advance  = run_en | step_req;
  assign cur_uni  = (&cells_q) | ~(|cells_q);
  assign nxt_uni  = (&nxt) | ~(|nxt);
  assign alt_step = cur_uni & nxt_uni & (nxt[0] != cells_q[0]);
  assign rule_ok  = cfg_we & ~run_en & (32'(cfg_addr) < N_CELLS);
  assign sync_flag = (32'(alt_cnt) >= SYNC_STEPS);

  always_ff @(posedge clk) begin
    if (!rst_n) rule_q <= '0;
    else if (rule_ok) rule_q[cfg_addr] <= cfg_rule;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells_q <= '0;
      lfsr_q  <= LFSR_INIT;
      alt_cnt <= '0;
    end else if (seed_load) begin
      alt_cnt <= '0;
      if (seed_src) cells_q <= seed_user;
      else begin
        cells_q <= seed_wide[N_CELLS-1:0];
        lfsr_q  <= lfsr_end;
      end
    end else if (advance) begin
      cells_q <= nxt;
      if (!alt_step) alt_cnt <= '0;
      else if (32'(alt_cnt) < SYNC_STEPS) alt_cnt <= alt_cnt + 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !step_req && !seed_load) |=> $stable(cells_q)); // R6
  AST_RULE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(rule_q)); // R5
  AST_SYNC_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flag |-> ((&cells_q) || !(|cells_q))); // R9
  AST_SYNC_RISE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> (cells_q != $past(cells_q))); // R9
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R8

endmodule

// File: tb/ca_ring_tb_top.sv
module ca_ring_tb_top;
  localparam int N = 56;

  logic clk = 0, rst_n = 0, run_en = 0, step_req = 0, cfg_we = 0;
  logic seed_load = 0, seed_src = 0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_rule = '0;
  logic [N-1:0] seed_user = '0, cells_q;
  logic sync_flag;

  ca_ring dut_i (.clk(clk), .rst_n(rst_n), .run_en(run_en), .step_req(step_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_rule(cfg_rule), .seed_load(seed_load),
    .seed_src(seed_src), .seed_user(seed_user), .cells_q(cells_q), .sync_flag(sync_flag));

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_rule [N];
  logic [N-1:0] m_cells;
  logic [15:0] m_lfsr;

  localparam logic [63:0] VEC [6] = '{
    {8'd90,  56'h00_0000_0100_0000},
    {8'd30,  56'h80_0000_0000_0001},
    {8'd110, 56'h12_3456_789A_BCDE},
    {8'd184, 56'hF0F0_F0F0_0F0F_0F},
    {8'd204, 56'hA5_5A5A_A5A5_5A5A},
    {8'd51,  56'h00_FF00_FF00_FF00}};

  function automatic logic [15:0] m_adv(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic logic [N-1:0] m_step(input logic [N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic [2:0] idx;
      idx = {c[(i + N - 1) % N], c[i], c[(i + 1) % N]};
      r[i] = m_rule[i][idx];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_rule(input int a, input logic [7:0] r);
    cfg_we = 1; cfg_addr = 6'(a); cfg_rule = r;
    @(negedge clk);
    cfg_we = 0;
    if (!run_en && a < N) m_rule[a] = r;
  endtask

  task automatic all_rules(input logic [7:0] r);
    for (int i = 0; i < N; i++) wr_rule(i, r);
  endtask

  task automatic load_user(input logic [N-1:0] p);
    seed_load = 1; seed_src = 1; seed_user = p;
    @(negedge clk);
    seed_load = 0;
    m_cells = p;
  endtask

  task automatic load_lfsr();
    seed_load = 1; seed_src = 0;
    @(negedge clk);
    seed_load = 0;
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 16; b++) if (16 * k + b < N) m_cells[16 * k + b] = m_lfsr[b];
      m_lfsr = m_adv(m_lfsr);
    end
  endtask

  task automatic step1();
    step_req = 1;
    @(negedge clk);
    step_req = 0;
    m_cells = m_step(m_cells);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_rule[i] = 8'h00;
    m_cells = '0; m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cells after reset", cells_q, '0);
    check("R1 sync after reset", N'(sync_flag), '0);
    load_user({N{1'b1}});
    step1();
    check("R1 zero rules clear ring", cells_q, '0);

    // Vector table: uniform rule, user seed, three single steps each (R2, R3)
    foreach (VEC[v]) begin
      all_rules(VEC[v][63:56]);
      load_user(VEC[v][55:0]);
      check("R7 user seed", cells_q, m_cells);
      for (int s = 0; s < 3; s++) begin
        step1();
        check("R2 table step", cells_q, m_cells);
      end
    end

    // R3 wrap: copy-left rule moves cell 55 into cell 0
    all_rules(8'hF0);
    load_user(56'h80_0000_0000_0000);
    step1();
    check("R3 wrap left edge", cells_q, 56'h00_0000_0000_0001);
    all_rules(8'hAA);
    load_user(56'h00_0000_0000_0001);
    step1();
    check("R3 wrap right edge", cells_q, 56'h80_0000_0000_0000);

    // R4 non-uniform rules with LFSR seed (R8)
    for (int i = 0; i < N; i++) wr_rule(i, 8'(i * 37 + 11));
    load_lfsr();
    check("R8 lfsr seed first", cells_q, m_cells);
    load_lfsr();
    check("R8 lfsr seed second", cells_q, m_cells);
    for (int s = 0; s < 4; s++) begin
      step1();
      check("R4 per-cell rules", cells_q, m_cells);
    end

    // R6 hold when idle
    repeat (3) @(negedge clk);
    check("R6 hold idle", cells_q, m_cells);

    // R6 free run five cycles, R5 write attempted during run is ignored
    run_en = 1;
    cfg_we = 1; cfg_addr = 6'd10; cfg_rule = ~m_rule[10];
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      cfg_we = 0;
      m_cells = m_step(m_cells);
    end
    run_en = 0;
    check("R6 free run", cells_q, m_cells);
    for (int s = 0; s < 3; s++) begin
      step1();
      check("R5 locked write ignored", cells_q, m_cells);
    end

    // R5 out-of-range addresses ignored
    wr_rule(56, 8'hFF); wr_rule(63, 8'hFF);
    step1();
    check("R5 out-of-range ignored", cells_q, m_cells);

    // R7 seed beats step in the same cycle
    seed_load = 1; seed_src = 1; seed_user = 56'h0F_1E2D_3C4B_5A69; step_req = 1;
    @(negedge clk);
    seed_load = 0; step_req = 0;
    m_cells = 56'h0F_1E2D_3C4B_5A69;
    check("R7 seed priority", cells_q, m_cells);

    // R9 synchronization detector
    all_rules(8'h01);
    load_user('0);
    for (int s = 1; s <= 3; s++) begin
      step1();
      check("R9 ring alternates", cells_q, m_cells);
      check("R9 no sync before 4", N'(sync_flag), '0);
    end
    step1();
    check("R9 sync at 4", N'(sync_flag), N'(1));
    step1();
    check("R9 sync holds", N'(sync_flag), N'(1));
    load_user(56'h1);
    check("R9 seed clears sync", N'(sync_flag), '0);
    all_rules(8'h00);
    load_user('0);
    for (int s = 0; s < 5; s++) step1();
    check("R9 static ring no sync", N'(sync_flag), '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule